// File: doc/BRIEF.md
# Downstream Port Power Controller

This block drives the power-enable lines of the four downstream ports of a full-speed USB hub. The hub's control logic sends it one-cycle power-on and power-off request pulses, one bit per port. The controller turns those pulses into four push-pull enable outputs. Each port also has an active-low overcurrent input. Every one of these inputs passes through a glitch filter first, so a short spike cannot switch off a port.

A strap input picks between two modes, and its level is captured while reset is held. In per-port mode, each enable, overcurrent input, status bit and change flag belongs to its own port. In ganged mode the four ports act as one group: any request bit switches the whole group, an overcurrent on any port shuts all four down, and status and change are shown as one shared value on every bit. After a shutdown a port stays off until the hub logic sends a new power-on request. A sticky change flag records every shutdown until the hub logic acknowledges it.

Top module: `port_power_ctrl`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `pwrEn`, `ocStatus` and `ocChange` are all zero.
- R2: In per-port mode, a high `pwrOnReq[i]` sets `pwrEn[i]` at the next clock edge and a high `pwrOffReq[i]` clears it. Other ports are not affected. If both are high in the same cycle, off wins.
- R3: In ganged mode, any set bit of `pwrOnReq` turns all four enables on at the next edge, and any set bit of `pwrOffReq` turns all four off. All four enables are always equal.
- R4: The filtered overcurrent state of a port becomes active only at the 8th consecutive clock edge at which its `ocN` is sampled low. It becomes inactive only at the 8th consecutive edge at which `ocN` is sampled high. A low pulse of 7 cycles or fewer has no effect on any output.
- R5: At the edge where a port's filtered overcurrent becomes active, its enable is cleared. In ganged mode all four enables are cleared.
- R6: At that same edge, the change flag of each affected port is set. In ganged mode that is all four flags. A flag stays set until an `ocAck` bit for it is sampled high. In ganged mode, any `ocAck` bit clears all four flags. A new event in the same cycle wins over an acknowledge.
- R7: After a shutdown, an enable comes back only after a new power-on request. A power-on request for a port is ignored while that port's filtered overcurrent is active. In ganged mode, a request to the group is ignored while any port's filtered overcurrent is active.
- R8: In per-port mode, `ocStatus[i]` shows the filtered overcurrent state of port i. In ganged mode, every bit of `ocStatus` shows the OR of all four filtered states.
- R9: The mode is the level of `gangStrap` (1 = ganged) during the last reset cycle. Changes to the strap after reset has been released have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Synchronous active-low reset |
| gangStrap | input | 1 | Mode strap: 1 ganged, 0 per-port |
| pwrOnReq | input | 4 | Power-on request pulses, one bit per port |
| pwrOffReq | input | 4 | Power-off request pulses, one bit per port |
| ocAck | input | 4 | Change-flag acknowledge, one bit per port |
| ocN | input | 4 | Active-low overcurrent inputs |
| pwrEn | output | 4 | Push-pull power-enable outputs |
| ocStatus | output | 4 | Filtered overcurrent status |
| ocChange | output | 4 | Sticky overcurrent change flags |

## Verification
On every cycle the assertions check four things. The reset values are zero. In ganged mode the enables always match. A status bit can only rise after 8 straight low samples, and an enable is always off at the edge where its status rises. A change flag stays set until it is acknowledged, and an enable can only rise after a power-on request. Some behaviours can only be shown by the bench's directed scenarios. These are the exact edge counts of the filter in both directions, and the rejection of a 7-cycle glitch. They also include requests being ignored while an overcurrent is active, the priority of power-off over power-on, the shared acknowledge in ganged mode, and the strap being ignored once reset is released.

// File: rtl/port_power_pkg.sv
package port_power_pkg;
  parameter int unsigned PORT_COUNT = 4;

  typedef struct packed {
    logic [PORT_COUNT-1:0] setEn;
    logic [PORT_COUNT-1:0] clrEn;
    logic [PORT_COUNT-1:0] setChg;
    logic [PORT_COUNT-1:0] clrChg;
  } pwr_strobe_t;
endpackage

// File: rtl/oc_glitch_filter.sv
module oc_glitch_filter #(
  parameter int unsigned FILT_LEN = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawActive,
  output logic filtState,
  output logic riseEvt
);
  localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [CW-1:0] runCnt;
  logic          differs;
  logic          flipNow;

  assign differs = rawActive != filtState;
  assign flipNow = differs && (runCnt == LAST);
  assign riseEvt = flipNow && !filtState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt    <= '0;
      filtState <= 1'b0;
    end else if (!differs || flipNow) begin
      runCnt    <= '0;
      filtState <= filtState ^ flipNow;
    end else begin
      runCnt    <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/port_power_datapath.sv
module port_power_datapath
  import port_power_pkg::*;
#(
  parameter int unsigned FILT_LEN = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PORT_COUNT-1:0] ocN,
  input  pwr_strobe_t           strobe,
  output logic [PORT_COUNT-1:0] ocFilt,
  output logic [PORT_COUNT-1:0] ocRise,
  output logic [PORT_COUNT-1:0] enState,
  output logic [PORT_COUNT-1:0] chgState
);
  for (genvar i = 0; i < PORT_COUNT; i++) begin : g_filt
    oc_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk       (clk),
      .rstN      (rstN),
      .rawActive (!ocN[i]),
      .filtState (ocFilt[i]),
      .riseEvt   (ocRise[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enState  <= '0;
      chgState <= '0;
    end else begin
      enState  <= (enState | strobe.setEn) & ~strobe.clrEn;
      chgState <= (chgState & ~strobe.clrChg) | strobe.setChg;
    end
  end
endmodule

// File: rtl/port_power_control.sv
module port_power_control
  import port_power_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  gangStrap,
  input  logic [PORT_COUNT-1:0] pwrOnReq,
  input  logic [PORT_COUNT-1:0] pwrOffReq,
  input  logic [PORT_COUNT-1:0] ocAck,
  input  logic [PORT_COUNT-1:0] ocFilt,
  input  logic [PORT_COUNT-1:0] ocRise,
  output pwr_strobe_t           strobe,
  output logic [PORT_COUNT-1:0] ocStatus
);
  localparam logic [PORT_COUNT-1:0] ALL = '1;

  logic gangMode;
  logic anyRise, anyOc;

  always_ff @(posedge clk) begin
    if (!rstN) gangMode <= gangStrap;
  end

  assign anyRise = |ocRise;
  assign anyOc   = |ocFilt;

  always_comb begin
    if (gangMode) begin
      strobe.setEn  = ((|pwrOnReq) && !anyOc) ? ALL : '0;
      strobe.clrEn  = ((|pwrOffReq) || anyRise) ? ALL : '0;
      strobe.setChg = anyRise ? ALL : '0;
      strobe.clrChg = (|ocAck) ? ALL : '0;
      ocStatus      = anyOc ? ALL : '0;
    end else begin
      strobe.setEn  = pwrOnReq & ~ocFilt;
      strobe.clrEn  = pwrOffReq | ocRise;
      strobe.setChg = ocRise;
      strobe.clrChg = ocAck;
      ocStatus      = ocFilt;
    end
  end
endmodule

// File: rtl/port_power_ctrl.sv
module port_power_ctrl
  import port_power_pkg::*;
#(
  parameter int unsigned FILT_LEN = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  gangStrap,
  input  logic [PORT_COUNT-1:0] pwrOnReq,
  input  logic [PORT_COUNT-1:0] pwrOffReq,
  input  logic [PORT_COUNT-1:0] ocAck,
  input  logic [PORT_COUNT-1:0] ocN,
  output logic [PORT_COUNT-1:0] pwrEn,
  output logic [PORT_COUNT-1:0] ocStatus,
  output logic [PORT_COUNT-1:0] ocChange
);
  pwr_strobe_t           strobe;
  logic [PORT_COUNT-1:0] ocFilt, ocRise;

  port_power_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .gangStrap (gangStrap),
    .pwrOnReq  (pwrOnReq),
    .pwrOffReq (pwrOffReq),
    .ocAck     (ocAck),
    .ocFilt    (ocFilt),
    .ocRise    (ocRise),
    .strobe    (strobe),
    .ocStatus  (ocStatus)
  );

  port_power_datapath #(.FILT_LEN(FILT_LEN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ocN      (ocN),
    .strobe   (strobe),
    .ocFilt   (ocFilt),
    .ocRise   (ocRise),
    .enState  (pwrEn),
    .chgState (ocChange)
  );
endmodule

// File: rtl/port_power_ctrl_chk.sv
module port_power_ctrl_chk
  import port_power_pkg::*;
#(
  parameter int unsigned FILT_LEN = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  gangStrap,
  input logic [PORT_COUNT-1:0] pwrOnReq,
  input logic [PORT_COUNT-1:0] ocAck,
  input logic [PORT_COUNT-1:0] ocN,
  input logic [PORT_COUNT-1:0] pwrEn,
  input logic [PORT_COUNT-1:0] ocStatus,
  input logic [PORT_COUNT-1:0] ocChange
);
  localparam int unsigned RW = $clog2(FILT_LEN + 1) + 1;

  logic modeSeen;
  always_ff @(posedge clk) begin
    if (!rstN) modeSeen <= gangStrap;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (pwrEn == '0 && ocChange == '0 && ocStatus == '0));

  // R3
  gang_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeSeen |-> (pwrEn == '0 || pwrEn == '1));

  for (genvar i = 0; i < PORT_COUNT; i++) begin : g_port
    logic [RW-1:0] lowRun;
    always_ff @(posedge clk) begin
      if (!rstN || ocN[i]) lowRun <= '0;
      else if (lowRun < RW'(FILT_LEN)) lowRun <= lowRun + 1'b1;
    end

    // R4
    filter_len_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!modeSeen && $rose(ocStatus[i])) |-> (lowRun >= RW'(FILT_LEN)));

    // R5
    oc_shutdown_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ocStatus[i]) |-> (!pwrEn[i] && ocChange[i]));

    // R6
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ocChange[i] && ocAck == '0) |=> ocChange[i]);

    // R7
    enable_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pwrEn[i]) |-> ($past(pwrOnReq) != '0));
  end
endmodule

bind port_power_ctrl port_power_ctrl_chk #(.FILT_LEN(FILT_LEN)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .gangStrap (gangStrap),
  .pwrOnReq  (pwrOnReq),
  .ocAck     (ocAck),
  .ocN       (ocN),
  .pwrEn     (pwrEn),
  .ocStatus  (ocStatus),
  .ocChange  (ocChange)
);

// File: tb/port_power_ctrl_bench.sv
module port_power_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       gangStrap;
  logic [3:0] pwrOnReq, pwrOffReq, ocAck, ocN;
  logic [3:0] pwrEn, ocStatus, ocChange;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_power_ctrl u_port_power_ctrl (
    .clk(clk), .rstN(rstN), .gangStrap(gangStrap),
    .pwrOnReq(pwrOnReq), .pwrOffReq(pwrOffReq), .ocAck(ocAck), .ocN(ocN),
    .pwrEn(pwrEn), .ocStatus(ocStatus), .ocChange(ocChange)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    rstN = 1'b0; gangStrap = strap;
    pwrOnReq = '0; pwrOffReq = '0; ocAck = '0; ocN = '1;
    cyc(3);
    chk("R1 pwrEn in reset", pwrEn, 4'b0000);
    chk("R1 ocChange in reset", ocChange, 4'b0000);
    rstN = 1'b1;
    cyc(1);
    chk("R1 pwrEn after release", pwrEn, 4'b0000);
    chk("R1 ocStatus after release", ocStatus, 4'b0000);
  endtask

  task automatic pulseOn(input logic [3:0] m);
    pwrOnReq = m; cyc(1); pwrOnReq = '0;
  endtask

  task automatic pulseOff(input logic [3:0] m);
    pwrOffReq = m; cyc(1); pwrOffReq = '0;
  endtask

  task automatic pulseAck(input logic [3:0] m);
    ocAck = m; cyc(1); ocAck = '0;
  endtask

  task automatic testPerPortSwitching();
    doReset(1'b0);
    pulseOn(4'b0101);
    chk("R2 per-port on", pwrEn, 4'b0101);
    pulseOff(4'b0001);
    chk("R2 per-port off", pwrEn, 4'b0100);
    pwrOnReq = 4'b1000; pwrOffReq = 4'b1000; cyc(1);
    pwrOnReq = '0; pwrOffReq = '0;
    chk("R2 off wins", pwrEn, 4'b0100);
  endtask

  task automatic testGlitch();
    ocN = 4'b1011; cyc(7); ocN = '1;
    chk("R4 7-cycle glitch status", ocStatus, 4'b0000);
    cyc(10);
    chk("R4 glitch enable kept", pwrEn, 4'b0100);
    chk("R4 glitch no flag", ocChange, 4'b0000);
  endtask

  task automatic testPerPortOc();
    pulseOn(4'b0010);
    chk("R2 second port on", pwrEn, 4'b0110);
    ocN = 4'b1011; cyc(7);
    chk("R4 status before 8th edge", ocStatus, 4'b0000);
    chk("R5 enable before 8th edge", pwrEn, 4'b0110);
    cyc(1);
    chk("R8 per-port status", ocStatus, 4'b0100);
    chk("R5 own port off", pwrEn, 4'b0010);
    chk("R6 own flag set", ocChange, 4'b0100);
    pulseOn(4'b0100);
    chk("R7 request ignored during oc", pwrEn, 4'b0010);
    ocN = '1; cyc(7);
    chk("R4 status held before 8th high", ocStatus, 4'b0100);
    cyc(1);
    chk("R4 status released", ocStatus, 4'b0000);
    cyc(5);
    chk("R7 no auto re-power", pwrEn, 4'b0010);
    chk("R6 flag sticky", ocChange, 4'b0100);
    pulseAck(4'b0001);
    chk("R6 other ack no effect", ocChange, 4'b0100);
    pulseAck(4'b0100);
    chk("R6 ack clears", ocChange, 4'b0000);
    pulseOn(4'b0100);
    chk("R7 new request re-powers", pwrEn, 4'b0110);
  endtask

  task automatic testGanged();
    doReset(1'b1);
    gangStrap = 1'b0;
    pulseOn(4'b0010);
    chk("R3 group on", pwrEn, 4'b1111);
    chk("R9 strap ignored after reset", pwrEn, 4'b1111);
    ocN = 4'b0111; cyc(8);
    chk("R5 ganged all off", pwrEn, 4'b0000);
    chk("R8 ganged shared status", ocStatus, 4'b1111);
    chk("R6 ganged all flags", ocChange, 4'b1111);
    pulseOn(4'b0001);
    chk("R7 ganged request ignored during oc", pwrEn, 4'b0000);
    ocN = '1; cyc(8);
    chk("R8 ganged status cleared", ocStatus, 4'b0000);
    chk("R7 ganged stays off", pwrEn, 4'b0000);
    pulseAck(4'b0001);
    chk("R6 ganged shared ack", ocChange, 4'b0000);
    pulseOn(4'b0001);
    chk("R7 ganged re-power", pwrEn, 4'b1111);
    pulseOff(4'b0100);
    chk("R3 group off", pwrEn, 4'b0000);
  endtask

  task automatic testStrapPerPort();
    doReset(1'b0);
    gangStrap = 1'b1;
    pulseOn(4'b0001);
    chk("R9 per-port kept after strap change", pwrEn, 4'b0001);
  endtask

  initial begin
    rstN = 1'b0; gangStrap = 1'b0;
    pwrOnReq = '0; pwrOffReq = '0; ocAck = '0; ocN = '1;
    testPerPortSwitching();
    testGlitch();
    testPerPortOc();
    testGanged();
    testStrapPerPort();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule